// File: doc/BRIEF.md
# Ping-Pong Program Page Loader

This block feeds an instruction fetch port from three fast pages of 32-bit words. One page is a fixed library of shared routines whose contents never change. The other two pages swap roles: the execution side reads the active one while a pager copies the next program segment out of a slow bulk memory into the inactive one. When the copy is done, a swap request makes the new page active. Loading a segment therefore overlaps with running the current one.

Each fetch carries a page-select bit that picks the library page or the current active page. A load request gives a bulk source address and a word count. The pager reads the bulk memory one word at a time over a request/acknowledge handshake whose latency can vary, and writes the words into the inactive page from word 0 upward. A load that arrives while another is running is refused. A swap that arrives before the inactive page is ready is held pending, and fetches stall until the swap can be taken. The block reports which page is active, whether the inactive page is ready, whether the pager is busy, and whether fetches are stalled.

Top module: `prog_page_loader`

## Requirements
- R1: After reset, page 1 is active (`active_page` = 1), and `page_ready`, `ld_busy`, `ld_reject`, `fetch_stall`, `fetch_rvalid` and `bm_req` are all 0.
- R2: A served fetch with `fetch_lib` = 1 returns the library word for `fetch_addr` a, equal to (a × 0x9E37) XOR 0xC0DE0000 in 32 bits. Loads and swaps never change it.
- R3: A fetch is served in every cycle where `fetch_valid` = 1 and `fetch_stall` = 0. `fetch_rvalid` is 1 in the following cycle and `fetch_data` then holds the addressed word of the page that was active in the request cycle, or of the library page.
- R4: A load of length L from source S writes bulk word (S + i) mod 2^BULK_AW into word i of the inactive page for i from 0 to L−1. Words at index L and above keep their earlier contents.
- R5: While `bm_req` = 1 and `bm_ack` = 0, `bm_req` stays 1 and `bm_addr` stays stable. Each cycle with `bm_ack` = 1 takes exactly one word from `bm_data`.
- R6: `ld_busy` is 1 from the cycle after a load with L > 0 is accepted until its last word is taken. A `ld_req` that arrives while `ld_busy` = 1 makes `ld_reject` 1 in the next cycle and has no effect on the running load.
- R7: `page_ready` becomes 1 in the cycle after the last word of a load is taken, or in the cycle after a load with L = 0 is accepted. It returns to 0 when a new load is accepted or a swap is taken.
- R8: A swap request while `page_ready` = 1 toggles the active page (1 and 2) at the next edge and clears `page_ready`. The active page never changes unless `page_ready` was 1.
- R9: A swap request while `page_ready` = 0 sets `fetch_stall` from the next cycle. Fetches during a stall are not served. The swap is taken in the cycle after `page_ready` rises, and the stall ends with it.
- R10: The pager never writes the active page. Fetches from the active page during a load return the data that was there before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch request |
| fetch_lib | input | 1 | 1 selects the library page, 0 the active page |
| fetch_addr | input | PAGE_AW | Word index within the page |
| fetch_rvalid | output | 1 | Fetch data valid (one cycle after a served request) |
| fetch_data | output | 32 | Fetched word |
| fetch_stall | output | 1 | Fetches are held off while a swap waits |
| ld_req | input | 1 | Start a segment load |
| ld_src | input | BULK_AW | Bulk source start address |
| ld_len | input | PAGE_AW+1 | Number of words to copy (0 to PAGE_WORDS) |
| ld_busy | output | 1 | Load in progress |
| ld_reject | output | 1 | Previous-cycle load request was refused |
| page_ready | output | 1 | Inactive page holds a completed load |
| swap_req | input | 1 | Request to make the inactive page active |
| active_page | output | 2 | Active page number, 1 or 2 |
| bm_req | output | 1 | Bulk read request, held until acknowledged |
| bm_addr | output | BULK_AW | Bulk read address |
| bm_ack | input | 1 | Bulk read acknowledge, data valid |
| bm_data | input | 32 | Bulk read data |

## Verification
The bench answers bulk reads with a latency that depends on the address, from zero to three wait cycles, so a pager that dropped or repeated a word on a slow acknowledge would leave shifted data in the page. One load wraps past the top of the bulk address space and stops short of the page end: a design that wrapped wrongly would show wrong words, and one that cleared the page tail would lose the older words there. A swap is requested in the middle of a load, and the bench checks the exact cycles of the stall and of the swap, so a design that swapped early would expose half-loaded data. The bench also sends a refused load during a busy load, a zero-length load, and fetches to the active page while the other page is being written. These catch a design that restarted the pager on a refused load, hung on a zero-length load, or wrote into the page that is executing.

// File: rtl/ppl_pkg.sv
package ppl_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_COPY = 1'b1
    } ld_state_e;

    // Fixed library page contents, computed from the word index.
    function automatic word_t lib_word(input logic [15:0] idx);
        return (WORD_W'(idx) * 32'h0000_9E37) ^ 32'hC0DE_0000;
    endfunction

endpackage

// File: rtl/ppl_page_ram.sv
module ppl_page_ram
    import ppl_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/ppl_pager.sv
module ppl_pager
    import ppl_pkg::*;
#(
    parameter int PAGE_AW = 9,
    parameter int BULK_AW = 15,
    localparam int CW     = PAGE_AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_req,
    input  logic [BULK_AW-1:0] ld_src,
    input  logic [CW-1:0]      ld_len,
    input  logic               swap_take,
    output logic               ld_busy,
    output logic               ld_reject,
    output logic               page_ready,
    output logic               bm_req,
    output logic [BULK_AW-1:0] bm_addr,
    input  logic               bm_ack,
    input  word_t              bm_data,
    output logic               wr_en,
    output logic [PAGE_AW-1:0] wr_addr,
    output word_t              wr_data
);

    ld_state_e          state_q;
    logic [CW-1:0]      cnt_q;
    logic [CW-1:0]      len_q;
    logic [BULK_AW-1:0] src_q;
    logic               ready_q;
    logic               reject_q;
    logic [CW-1:0]      cnt_nxt;

    assign cnt_nxt = cnt_q + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LD_IDLE;
            cnt_q    <= '0;
            len_q    <= '0;
            src_q    <= '0;
            ready_q  <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= ld_req && (state_q == LD_COPY);
            if (swap_take) begin
                ready_q <= 1'b0;
            end
            if (state_q == LD_IDLE) begin
                if (ld_req) begin
                    src_q <= ld_src;
                    len_q <= ld_len;
                    cnt_q <= '0;
                    if (ld_len == '0) begin
                        ready_q <= 1'b1;
                    end else begin
                        ready_q <= 1'b0;
                        state_q <= LD_COPY;
                    end
                end
            end else if (bm_ack) begin
                cnt_q <= cnt_nxt;
                if (cnt_nxt == len_q) begin
                    state_q <= LD_IDLE;
                    ready_q <= 1'b1;
                end
            end
        end
    end

    assign ld_busy    = (state_q == LD_COPY);
    assign ld_reject  = reject_q;
    assign page_ready = ready_q;
    assign bm_req     = ld_busy;
    assign bm_addr    = src_q + BULK_AW'(cnt_q);
    assign wr_en      = ld_busy && bm_ack;
    assign wr_addr    = cnt_q[PAGE_AW-1:0];
    assign wr_data    = bm_data;

    AST_BM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bm_req && !bm_ack) |=> (bm_req && $stable(bm_addr))); // R5

    AST_REJECT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ld_req && ld_busy) |=> ld_reject); // R6

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        page_ready |-> !ld_busy); // R7

endmodule

// File: rtl/ppl_swap_ctl.sv
module ppl_swap_ctl (
    input  logic clk,
    input  logic rst,
    input  logic swap_req,
    input  logic page_ready,
    output logic swap_take,
    output logic active_sel,
    output logic stall
);

    logic pend_q;
    logic act_q;
    logic want;

    assign want      = swap_req || pend_q;
    assign swap_take = want && page_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            act_q  <= 1'b0;
        end else if (swap_take) begin
            act_q  <= ~act_q;
            pend_q <= 1'b0;
        end else if (want) begin
            pend_q <= 1'b1;
        end
    end

    assign active_sel = act_q;
    assign stall      = pend_q;

    AST_SWAP_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_sel) |-> $past(page_ready)); // R8

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (stall && !page_ready) |=> (stall && $stable(active_sel))); // R9

endmodule

// File: rtl/prog_page_loader.sv
module prog_page_loader
    import ppl_pkg::*;
#(
    parameter int PAGE_WORDS = 512,
    parameter int BULK_AW    = 15,
    localparam int PAGE_AW   = $clog2(PAGE_WORDS),
    localparam int NBANK     = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_valid,
    input  logic               fetch_lib,
    input  logic [PAGE_AW-1:0] fetch_addr,
    output logic               fetch_rvalid,
    output logic [31:0]        fetch_data,
    output logic               fetch_stall,
    input  logic               ld_req,
    input  logic [BULK_AW-1:0] ld_src,
    input  logic [PAGE_AW:0]   ld_len,
    output logic               ld_busy,
    output logic               ld_reject,
    output logic               page_ready,
    input  logic               swap_req,
    output logic [1:0]         active_page,
    output logic               bm_req,
    output logic [BULK_AW-1:0] bm_addr,
    input  logic               bm_ack,
    input  logic [31:0]        bm_data
);

    logic               swap_take;
    logic               act_sel;
    logic               wr_en;
    logic [PAGE_AW-1:0] wr_addr;
    word_t              wr_data;
    logic               fetch_go;
    word_t              bank_q [NBANK];
    word_t              lib_q;
    logic               sel_lib_q;
    logic               sel_bank_q;
    logic               rvalid_q;

    ppl_pager #(.PAGE_AW(PAGE_AW), .BULK_AW(BULK_AW)) u_pager (
        .clk        (clk),
        .rst        (rst),
        .ld_req     (ld_req),
        .ld_src     (ld_src),
        .ld_len     (ld_len),
        .swap_take  (swap_take),
        .ld_busy    (ld_busy),
        .ld_reject  (ld_reject),
        .page_ready (page_ready),
        .bm_req     (bm_req),
        .bm_addr    (bm_addr),
        .bm_ack     (bm_ack),
        .bm_data    (bm_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    ppl_swap_ctl u_swap (
        .clk        (clk),
        .rst        (rst),
        .swap_req   (swap_req),
        .page_ready (page_ready),
        .swap_take  (swap_take),
        .active_sel (act_sel),
        .stall      (fetch_stall)
    );

    assign fetch_go = fetch_valid && !fetch_stall;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic is_active;
        assign is_active = (act_sel == 1'(b));
        ppl_page_ram #(.DEPTH(PAGE_WORDS)) u_ram (
            .clk   (clk),
            .we    (wr_en && !is_active),
            .waddr (wr_addr),
            .wdata (wr_data),
            .re    (fetch_go && !fetch_lib && is_active),
            .raddr (fetch_addr),
            .rdata (bank_q[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q   <= 1'b0;
            sel_lib_q  <= 1'b0;
            sel_bank_q <= 1'b0;
            lib_q      <= '0;
        end else begin
            rvalid_q <= fetch_go;
            if (fetch_go) begin
                sel_lib_q  <= fetch_lib;
                sel_bank_q <= act_sel;
                if (fetch_lib) begin
                    lib_q <= lib_word(16'(fetch_addr));
                end
            end
        end
    end

    assign fetch_rvalid = rvalid_q;
    assign fetch_data   = sel_lib_q ? lib_q : bank_q[sel_bank_q];
    assign active_page  = act_sel ? 2'd2 : 2'd1;

    AST_FETCH_SERVED: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !fetch_stall) |=> fetch_rvalid); // R3

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |=> !fetch_rvalid); // R9

    AST_NO_WRITE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ld_busy) |-> !swap_take); // R10

endmodule

// File: tb/prog_page_loader_tb.sv
module prog_page_loader_tb;

    localparam int PW      = 64;
    localparam int PAW     = $clog2(PW);
    localparam int BAW     = 15;
    localparam int BMASK   = (1 << BAW) - 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           fetch_valid = 1'b0;
    logic           fetch_lib = 1'b0;
    logic [PAW-1:0] fetch_addr = '0;
    logic           fetch_rvalid;
    logic [31:0]    fetch_data;
    logic           fetch_stall;
    logic           ld_req = 1'b0;
    logic [BAW-1:0] ld_src = '0;
    logic [PAW:0]   ld_len = '0;
    logic           ld_busy;
    logic           ld_reject;
    logic           page_ready;
    logic           swap_req = 1'b0;
    logic [1:0]     active_page;
    logic           bm_req;
    logic [BAW-1:0] bm_addr;
    logic           bm_ack = 1'b0;
    logic [31:0]    bm_data = '0;

    int checks = 0;
    int failures = 0;
    int acks = 0;
    int wcnt = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    prog_page_loader #(.PAGE_WORDS(PW), .BULK_AW(BAW)) u_dut (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_lib(fetch_lib), .fetch_addr(fetch_addr),
        .fetch_rvalid(fetch_rvalid), .fetch_data(fetch_data), .fetch_stall(fetch_stall),
        .ld_req(ld_req), .ld_src(ld_src), .ld_len(ld_len),
        .ld_busy(ld_busy), .ld_reject(ld_reject), .page_ready(page_ready),
        .swap_req(swap_req), .active_page(active_page),
        .bm_req(bm_req), .bm_addr(bm_addr), .bm_ack(bm_ack), .bm_data(bm_data)
    );

    function automatic logic [31:0] bulk_word(input int a);
        return (32'(a) * 32'h0001_0001) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] lib_exp(input int a);
        return (32'(a) * 32'h0000_9E37) ^ 32'hC0DE_0000;
    endfunction

    // Bulk memory model: address-dependent wait of 0..3 cycles.
    always @(negedge clk) begin
        if (rst) begin
            bm_ack <= 1'b0;
            wcnt = 0;
        end else if (bm_ack) begin
            bm_ack <= 1'b0;
            wcnt = 0;
        end else if (bm_req) begin
            if (wcnt >= int'(bm_addr) % 4) begin
                bm_ack  <= 1'b1;
                bm_data <= bulk_word(int'(bm_addr));
            end else begin
                wcnt++;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst && bm_ack && bm_req) acks++;
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=150000 cycles", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fetch(input bit lib, input int a, input string req, input logic [31:0] exp);
        fetch_valid = 1'b1;
        fetch_lib   = lib;
        fetch_addr  = PAW'(a);
        @(negedge clk);
        fetch_valid = 1'b0;
        chk(req, {31'b0, fetch_rvalid}, 32'd1);
        chk(req, fetch_data, exp);
    endtask

    task automatic start_load(input int src, input int len);
        acks   = 0;
        ld_req = 1'b1;
        ld_src = BAW'(src);
        ld_len = (PAW+1)'(len);
        @(negedge clk);
        ld_req = 1'b0;
    endtask

    task automatic wait_done(input int len);
        while (acks != len) @(negedge clk);
        chk("R7 ready after last word", {31'b0, page_ready}, 32'd1);
        chk("R6 busy clears", {31'b0, ld_busy}, 32'd0);
    endtask

    task automatic swap_now(input int exp_page);
        swap_req = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
        chk("R8 active toggles", 32'(active_page), 32'(exp_page));
        chk("R8 ready cleared", {31'b0, page_ready}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 active", 32'(active_page), 32'd1);
        chk("R1 ready", {31'b0, page_ready}, 32'd0);
        chk("R1 busy", {31'b0, ld_busy}, 32'd0);
        chk("R1 reject", {31'b0, ld_reject}, 32'd0);
        chk("R1 stall", {31'b0, fetch_stall}, 32'd0);
        chk("R1 rvalid", {31'b0, fetch_rvalid}, 32'd0);
        chk("R1 bm_req", {31'b0, bm_req}, 32'd0);

        // R2 library sweep
        for (int i = 0; i < PW; i++) fetch(1'b1, i, "R2 library", lib_exp(i));

        // Load A into page 2, with a refused request in the middle (R6)
        start_load(100, PW);
        chk("R6 busy", {31'b0, ld_busy}, 32'd1);
        ld_req = 1'b1; ld_src = BAW'(900); ld_len = (PAW+1)'(5);
        @(negedge clk);
        ld_req = 1'b0;
        chk("R6 reject", {31'b0, ld_reject}, 32'd1);
        chk("R5 request held", {31'b0, bm_req}, 32'd1);
        wait_done(PW);
        swap_now(2);
        for (int i = 0; i < PW; i++) fetch(1'b0, i, "R4 R3 page2 load A", bulk_word(100 + i));

        // Load B into page 1 while fetching from page 2 (R10)
        start_load(5000, PW);
        for (int i = 0; i < 8; i++) fetch(1'b0, i * 7, "R10 active untouched", bulk_word(100 + i * 7));
        wait_done(PW);
        swap_now(1);
        for (int i = 0; i < PW; i++) fetch(1'b0, i, "R4 page1 load B", bulk_word(5000 + i));

        // Load C wraps the bulk space, short length, swap requested early (R9)
        start_load(32760, 20);
        swap_req = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
        chk("R9 stall set", {31'b0, fetch_stall}, 32'd1);
        fetch_valid = 1'b1; fetch_lib = 1'b0; fetch_addr = '0;
        @(negedge clk);
        fetch_valid = 1'b0;
        chk("R9 stalled fetch not served", {31'b0, fetch_rvalid}, 32'd0);
        wait_done(20);
        chk("R9 still stalled at ready", {31'b0, fetch_stall}, 32'd1);
        chk("R9 no early swap", 32'(active_page), 32'd1);
        @(negedge clk);
        chk("R9 swap taken", 32'(active_page), 32'd2);
        chk("R9 stall ends", {31'b0, fetch_stall}, 32'd0);
        chk("R8 ready cleared by swap", {31'b0, page_ready}, 32'd0);
        for (int i = 0; i < PW; i++) begin
            if (i < 20) fetch(1'b0, i, "R4 wrapped words", bulk_word((32760 + i) & BMASK));
            else        fetch(1'b0, i, "R4 tail kept", bulk_word(100 + i));
        end

        // Library unchanged after loads (R2)
        for (int i = 0; i < PW; i += 5) fetch(1'b1, i, "R2 library after loads", lib_exp(i));

        // Zero-length load (R7)
        start_load(7, 0);
        chk("R7 zero-length ready", {31'b0, page_ready}, 32'd1);
        chk("R7 zero-length not busy", {31'b0, ld_busy}, 32'd0);
        chk("R5 no bulk read", {31'b0, bm_req}, 32'd0);
        swap_now(1);
        for (int i = 0; i < PW; i += 9) fetch(1'b0, i, "R4 page1 kept", bulk_word(5000 + i));

        summary();
    end

endmodule